// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer behind a small memory-mapped register port with one address bus, one write strobe, write data and registered read data. An up-counter advances on a slow tick-enable input that stands in for a low-power timebase. While the timer is enabled, the counter reaching the programmed limit drives a reset request that stays asserted until system reset.

Software cannot touch the configuration directly. It first writes an unlock key to the command register. That opens a short window in which the control word and the limit may be written. A different key written to the same register restarts the count. Keys can be given as one 32-bit word or as two consecutive 16-bit halves, chosen by a mode bit in the control word. A control write that clears the update-permit bit locks the configuration until the next reset. While the timer is enabled, any malformed command write is treated as a fault and trips the reset immediately.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x0000_0020, the limit (offset 0x8) reads DEF_TIMEOUT, the count (offset 0x4) reads 0 and `wdog_rst` is low.
- R2: With control bit 13 set (32-bit key mode), one write of 0xD928C520 to offset 0x4 opens the unlock window, so control bit 11 reads 1. One write of 0xB480A602 clears the count to 0.
- R3: With control bit 13 clear (16-bit key mode), the unlock is 0x0000C520 followed by 0x0000D928, and the restart is 0x0000A602 followed by 0x0000B480, both as consecutive writes to offset 0x4. A write to any other offset between the two halves cancels the pending first half.
- R4: While the window is closed, writes to offsets 0x0 and 0x8 leave both registers unchanged.
- R5: The unlock window accepts writes on exactly WIN_LEN clock edges after the edge that accepted the key. After that, bit 11 reads 0 and further writes are ignored.
- R6: An accepted control write closes the window at once and sets control bit 10. The next accepted unlock clears bit 10.
- R7: After an accepted control write with bit 5 clear, unlock keys are ignored until reset.
- R8: While enabled (control bit 7), the count rises by one on each clock edge with `tick_en` high. While disabled, the count is held at 0.
- R9: While enabled, a count equal to the limit raises `wdog_rst` on the next clock edge, and `wdog_rst` then stays high until reset.
- R10: While enabled, a write to offset 0x4 that is neither a key nor a valid key half for the current mode raises `wdog_rst` on that write's clock edge. While disabled, such a write has no effect.
- R11: Control bit 8 is stored and read back unchanged. `bus_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow timebase enable for the counter |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wdog_rst | output | 1 | Sticky watchdog reset request |

## Verification
Register writes take effect on the clock edge that samples the strobe, and read data appears one edge after the address is presented. The bench drives every input on the falling edge, so it reads back one full cycle after each write. A malformed key shows on `wdog_rst` at the write's own edge, while a count match shows one edge after the count reaches the limit, because the comparison uses the registered count. The bench samples the reset output before and after that edge to pin the latency down. The window test counts edges from the accepting key and writes on the last edge that should pass and on the first edge that should fail.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;

  // full-word command keys
  localparam logic [31:0] KEY32_OPEN  = 32'hD928_C520;
  localparam logic [31:0] KEY32_KICK  = 32'hB480_A602;
  // half-word command keys: first then second
  localparam logic [15:0] KEY16_OPEN_A = 16'hC520;
  localparam logic [15:0] KEY16_OPEN_B = 16'hD928;
  localparam logic [15:0] KEY16_KICK_A = 16'hA602;
  localparam logic [15:0] KEY16_KICK_B = 16'hB480;

  // control word bit positions
  localparam int CB_WIDE   = 13;
  localparam int CB_OPEN   = 11;
  localparam int CB_DONE   = 10;
  localparam int CB_SRC    = 8;
  localparam int CB_RUN    = 7;
  localparam int CB_PERMIT = 5;

  // register word index (byte address bits [3:2])
  localparam logic [1:0] IDX_CTRL  = 2'd0;
  localparam logic [1:0] IDX_CMD   = 2'd1;
  localparam logic [1:0] IDX_LIMIT = 2'd2;

  typedef struct packed {
    logic wide;    // 32-bit key mode
    logic src;     // stored clock-source select bit
    logic run;     // timer enable
    logic permit;  // further updates allowed
  } ctrl_t;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_OPEN_HALF,
    KS_KICK_HALF
  } kseq_e;

endpackage

// File: rtl/kwdt_keyseq.sv
`timescale 1ns/1ps
module kwdt_keyseq
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              other_wr,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_hit,
  output logic              kick_hit,
  output logic              bad_key
);

  localparam int HI_W = DATA_W - 16;

  kseq_e state_q, state_d;
  logic  hi_zero;
  logic [15:0] lo;

  assign hi_zero = (wdata[DATA_W-1:16] == {HI_W{1'b0}});
  assign lo      = wdata[15:0];

  always_comb begin
    state_d  = state_q;
    open_hit = 1'b0;
    kick_hit = 1'b0;
    bad_key  = 1'b0;
    if (cmd_wr) begin
      state_d = KS_IDLE;
      if (wide) begin
        if (wdata == DATA_W'(KEY32_OPEN))      open_hit = 1'b1;
        else if (wdata == DATA_W'(KEY32_KICK)) kick_hit = 1'b1;
        else                                   bad_key  = 1'b1;
      end else begin
        if (state_q == KS_OPEN_HALF && hi_zero && lo == KEY16_OPEN_B)
          open_hit = 1'b1;
        else if (state_q == KS_KICK_HALF && hi_zero && lo == KEY16_KICK_B)
          kick_hit = 1'b1;
        else if (hi_zero && lo == KEY16_OPEN_A)
          state_d = KS_OPEN_HALF;
        else if (hi_zero && lo == KEY16_KICK_A)
          state_d = KS_KICK_HALF;
        else
          bad_key = 1'b1;
      end
    end else if (other_wr) begin
      state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/kwdt_cfg.sv
`timescale 1ns/1ps
module kwdt_cfg
  import kwdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WIN_LEN     = 128,
  parameter int DEF_TIMEOUT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_hit,
  input  logic             ctrl_wr,
  input  logic             limit_wr,
  input  ctrl_t            ctrl_in,
  input  logic [CNT_W-1:0] limit_in,
  output ctrl_t            ctrl_q,
  output logic             unlocked,
  output logic             done,
  output logic [CNT_W-1:0] limit_q
);

  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [WIN_W-1:0] win_q;
  logic ctrl_acc, limit_acc, open_acc;

  assign ctrl_acc  = ctrl_wr && unlocked;
  assign limit_acc = limit_wr && unlocked;
  assign open_acc  = open_hit && ctrl_q.permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '{wide: 1'b0, src: 1'b0, run: 1'b0, permit: 1'b1};
      unlocked <= 1'b0;
      done     <= 1'b0;
      win_q    <= '0;
    end else begin
      if (ctrl_acc) begin
        ctrl_q   <= ctrl_in;
        done     <= 1'b1;
        unlocked <= 1'b0;
      end else if (open_acc) begin
        unlocked <= 1'b1;
        done     <= 1'b0;
        win_q    <= WIN_W'(WIN_LEN - 1);
      end else if (unlocked) begin
        if (win_q == '0) unlocked <= 1'b0;
        else             win_q    <= win_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            limit_q <= CNT_W'(DEF_TIMEOUT);
    else if (limit_acc) limit_q <= limit_in;
  end

endmodule

// File: rtl/kwdt_cnt.sv
`timescale 1ns/1ps
module kwdt_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic             kick,
  input  logic             bad_key,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wdog_rst
);

  logic at_limit;
  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || kick) begin
      cnt_q <= '0;
    end else if (tick_en && cnt_q != {CNT_W{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              wdog_rst <= 1'b0;
    else if (run && (at_limit || bad_key)) wdog_rst <= 1'b1;
  end

endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int WIN_LEN     = 128,
  parameter int DEF_TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rst
);

  logic [1:0]       reg_idx;
  logic             addr_hi_ok, addr_ok;
  logic             ctrl_wr, cmd_wr, limit_wr, other_wr;
  logic             open_hit, kick_hit, bad_key;
  ctrl_t            ctrl_q, ctrl_in;
  logic             unlocked, done;
  logic [CNT_W-1:0] limit_q, cnt_q;
  logic [DATA_W-1:0] ctrl_word;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign addr_hi_ok = (bus_addr[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign addr_hi_ok = 1'b1;
    end
  endgenerate

  assign reg_idx  = bus_addr[3:2];
  assign addr_ok  = addr_hi_ok && (bus_addr[1:0] == 2'b00);
  assign ctrl_wr  = bus_wr && addr_ok && (reg_idx == IDX_CTRL);
  assign cmd_wr   = bus_wr && addr_ok && (reg_idx == IDX_CMD);
  assign limit_wr = bus_wr && addr_ok && (reg_idx == IDX_LIMIT);
  assign other_wr = bus_wr && !cmd_wr;

  assign ctrl_in.wide   = bus_wdata[CB_WIDE];
  assign ctrl_in.src    = bus_wdata[CB_SRC];
  assign ctrl_in.run    = bus_wdata[CB_RUN];
  assign ctrl_in.permit = bus_wdata[CB_PERMIT];

  kwdt_keyseq #(.DATA_W(DATA_W)) u_keyseq (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .other_wr (other_wr),
    .wide     (ctrl_q.wide),
    .wdata    (bus_wdata),
    .open_hit (open_hit),
    .kick_hit (kick_hit),
    .bad_key  (bad_key)
  );

  kwdt_cfg #(
    .CNT_W       (CNT_W),
    .WIN_LEN     (WIN_LEN),
    .DEF_TIMEOUT (DEF_TIMEOUT)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .open_hit (open_hit),
    .ctrl_wr  (ctrl_wr),
    .limit_wr (limit_wr),
    .ctrl_in  (ctrl_in),
    .limit_in (bus_wdata[CNT_W-1:0]),
    .ctrl_q   (ctrl_q),
    .unlocked (unlocked),
    .done     (done),
    .limit_q  (limit_q)
  );

  kwdt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.run),
    .tick_en  (tick_en),
    .kick     (kick_hit),
    .bad_key  (bad_key),
    .limit    (limit_q),
    .cnt_q    (cnt_q),
    .wdog_rst (wdog_rst)
  );

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CB_WIDE]   = ctrl_q.wide;
    ctrl_word[CB_OPEN]   = unlocked;
    ctrl_word[CB_DONE]   = done;
    ctrl_word[CB_SRC]    = ctrl_q.src;
    ctrl_word[CB_RUN]    = ctrl_q.run;
    ctrl_word[CB_PERMIT] = ctrl_q.permit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (!addr_ok) begin
      bus_rdata <= '0;
    end else begin
      case (reg_idx)
        IDX_CTRL:  bus_rdata <= ctrl_word;
        IDX_CMD:   bus_rdata <= DATA_W'(cnt_q);
        IDX_LIMIT: bus_rdata <= DATA_W'(limit_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/kwdt_sva.sv
`timescale 1ns/1ps
module kwdt_sva #(
  parameter int CNT_W   = 16,
  parameter int WIN_LEN = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic             limit_wr,
  input logic             open_hit,
  input logic             kick_hit,
  input logic             bad_key,
  input logic             unlocked,
  input logic             done,
  input logic             run,
  input logic             permit,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] limit_q,
  input logic             wdog_rst
);

  localparam int AGE_W = $clog2(WIN_LEN + 1);
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                        age_q <= '0;
    else if (open_hit && permit)    age_q <= '0;
    else if (unlocked)              age_q <= age_q + 1'b1;
    else                            age_q <= '0;
  end

  p_kick_clears_r2: assert property (@(posedge clk) disable iff (rst)
    kick_hit |=> (cnt_q == '0));

  p_locked_limit_r4: assert property (@(posedge clk) disable iff (rst)
    (limit_wr && !unlocked) |=> $stable(limit_q));

  p_window_len_r5: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (age_q < AGE_W'(WIN_LEN)));

  p_ctrl_closes_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && unlocked) |=> (!unlocked && done));

  p_no_reopen_r7: assert property (@(posedge clk) disable iff (rst)
    (!permit && !unlocked) |=> !unlocked);

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  p_expire_r9: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == limit_q) |=> wdog_rst);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> wdog_rst);

  p_bad_key_r10: assert property (@(posedge clk) disable iff (rst)
    (run && bad_key) |=> wdog_rst);

endmodule

bind kwdt_top kwdt_sva #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .ctrl_wr  (ctrl_wr),
  .limit_wr (limit_wr),
  .open_hit (open_hit),
  .kick_hit (kick_hit),
  .bad_key  (bad_key),
  .unlocked (unlocked),
  .done     (done),
  .run      (ctrl_q.run),
  .permit   (ctrl_q.permit),
  .cnt_q    (cnt_q),
  .limit_q  (limit_q),
  .wdog_rst (wdog_rst)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_CMD   = 4'h4;
  localparam logic [3:0] A_LIMIT = 4'h8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              wdog_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  kwdt_top u_kwdt_top (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdog_rst  (wdog_rst)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic open16();
    wr(A_CMD, 32'h0000_C520);
    wr(A_CMD, 32'h0000_D928);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0000_0020);
    rd(A_LIMIT, v); chk("R1 limit", v, 32'd1000);
    rd(A_CMD, v);   chk("R1 count", v, 32'd0);
    chk("R1 wdog_rst", {31'b0, wdog_rst}, 32'd0);
  endtask

  task automatic t_locked_writes();
    logic [31:0] v;
    wr(A_LIMIT, 32'd55);
    rd(A_LIMIT, v); chk("R4 limit locked", v, 32'd1000);
    wr(A_CTRL, 32'h0000_20A0);
    rd(A_CTRL, v);  chk("R4 ctrl locked", v, 32'h0000_0020);
    tick(3);
    rd(A_CMD, v);   chk("R8 disabled count", v, 32'd0);
  endtask

  task automatic t_open16_config();
    logic [31:0] v;
    open16();
    rd(A_CTRL, v);  chk("R3 half-key unlock", v, 32'h0000_0820);
    wr(A_LIMIT, 32'd20);
    rd(A_LIMIT, v); chk("R3 limit accepted", v, 32'd20);
    wr(A_CTRL, 32'h0000_2120);
    rd(A_CTRL, v);  chk("R6 R11 ctrl write closes, sets done, keeps src", v, 32'h0000_2520);
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr(A_CMD, 32'hD928_C520);
    repeat (127) @(negedge clk);
    wr(A_LIMIT, 32'd33);           // last edge inside the window
    rd(A_LIMIT, v); chk("R5 last window edge", v, 32'd33);
    wr(A_CMD, 32'hD928_C520);
    repeat (128) @(negedge clk);
    wr(A_LIMIT, 32'd44);           // first edge past the window
    rd(A_LIMIT, v); chk("R5 after window", v, 32'd33);
    rd(A_CTRL, v);  chk("R5 open flag cleared", v[11], 32'd0);
  endtask

  task automatic t_count_expire();
    logic [31:0] v;
    wr(A_CMD, 32'hD928_C520);
    rd(A_CTRL, v);  chk("R2 R6 R11 wide unlock", v, 32'h0000_2920);
    wr(A_LIMIT, 32'd5);
    wr(A_CTRL, 32'h0000_20A0);
    rd(A_CTRL, v);  chk("R6 enable write", v, 32'h0000_24A0);
    tick(3);
    rd(A_CMD, v);   chk("R8 count ticks", v, 32'd3);
    wr(A_CMD, 32'hB480_A602);
    rd(A_CMD, v);   chk("R2 wide restart", v, 32'd0);
    tick(4);
    rd(A_CMD, v);   chk("R8 count after restart", v, 32'd4);
    chk("R9 below limit", {31'b0, wdog_rst}, 32'd0);
    tick(1);
    chk("R9 match edge not yet", {31'b0, wdog_rst}, 32'd0);
    @(negedge clk);
    chk("R9 trip one edge later", {31'b0, wdog_rst}, 32'd1);
    wr(A_CMD, 32'hB480_A602);
    repeat (5) @(negedge clk);
    chk("R9 held", {31'b0, wdog_rst}, 32'd1);
    reset_dut();
    chk("R1 cleared by reset", {31'b0, wdog_rst}, 32'd0);
  endtask

  task automatic t_half_keys_and_fault();
    logic [31:0] v;
    wr(A_CMD, 32'h0000_1234);
    chk("R10 junk while disabled", {31'b0, wdog_rst}, 32'd0);
    wr(A_CMD, 32'h0000_C520);
    wr(A_LIMIT, 32'h77);
    wr(A_CMD, 32'h0000_D928);
    rd(A_CTRL, v);  chk("R3 cancelled half", v, 32'h0000_0020);
    rd(A_LIMIT, v); chk("R4 limit untouched", v, 32'd1000);
    open16();
    rd(A_CTRL, v);  chk("R3 unlock after cancel", v, 32'h0000_0820);
    wr(A_LIMIT, 32'd100);
    wr(A_CTRL, 32'h0000_00A0);
    rd(A_CTRL, v);  chk("R3 narrow enable", v, 32'h0000_04A0);
    tick(2);
    rd(A_CMD, v);   chk("R8 narrow count", v, 32'd2);
    wr(A_CMD, 32'h0000_A602);
    wr(A_CMD, 32'h0000_B480);
    rd(A_CMD, v);   chk("R3 half-key restart", v, 32'd0);
    chk("R3 no fault on halves", {31'b0, wdog_rst}, 32'd0);
    wr(A_CMD, 32'hB480_A602);
    chk("R10 wide key in narrow mode", {31'b0, wdog_rst}, 32'd1);
    reset_dut();
  endtask

  task automatic t_update_lock();
    logic [31:0] v;
    open16();
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, v);  chk("R7 permit cleared", v, 32'h0000_0400);
    open16();
    rd(A_CTRL, v);  chk("R7 unlock refused", v, 32'h0000_0400);
    wr(A_LIMIT, 32'd7);
    rd(A_LIMIT, v); chk("R7 limit stays", v, 32'd1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_locked_writes();
    t_open16_config();
    t_window();
    t_count_expire();
    t_half_keys_and_fault();
    t_update_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule